// File: doc/BRIEF.md
# Countdown Timer with Interrupt

This block is a down-counting cycle timer driven by one custom instruction. The instruction logic raises a load strobe with a new count. In that same cycle the block hands back the count that was current before the load, which becomes the instruction's result.

From the next edge the count goes down by one on every clock while it is nonzero. When the count steps from one to zero, the block emits a single-cycle interrupt request for an external pending register to latch.

A count of zero means the timer is idle. The counter rests at zero, never wraps, and never raises a request from that state. A load always overrides the decrement that would otherwise happen in the same cycle.

Top module: `cyc_timer`

## Requirements
- R1: After reset the count output reads zero and the interrupt output is low.
- R2: When the load strobe is high at a clock edge, the count output shows the load value from that edge on.
- R3: While the load strobe is high, the previous-value output equals the count that was current before the load takes effect, in the same cycle.
- R4: Without a load, a nonzero count decreases by exactly one per clock edge; the count 0xFFFFFFFF steps to 0xFFFFFFFE.
- R5: Without a load, a zero count stays zero and never wraps to the maximum value.
- R6: When the count steps from one to zero by decrement, the interrupt output is high for exactly the one cycle in which the count first reads zero.
- R7: Loading zero stops a running count, and no interrupt follows.
- R8: A load that arrives in the cycle where the count is one takes precedence: the count takes the loaded value and no interrupt is raised.
- R9: Loading one from the idle state produces the interrupt pulse one cycle after the count reads one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_valid_i | input | 1 | Load strobe from the instruction logic |
| load_value_i | input | 32 | New count to load |
| prev_value_o | output | 32 | Count before the load, returned as the instruction result |
| count_o | output | 32 | Current count, for observation |
| irq_o | output | 1 | One-cycle timer interrupt request |

## Verification
The hardest case to reach is the collision, where a load lands in exactly the cycle the count is one. The bench can only hit it by counting edges from a known small load. It loads two, waits until the count output reads one, and then raises the strobe on that cycle. It confirms that no pulse appears and that the new value proceeds downward. The wrap boundary is reached by loading the all-ones value directly.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_LOAD = 2'd1,
        STEP_DECR = 2'd2
    } step_e;

endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import cyc_timer_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_valid_i,
    input  logic [WIDTH-1:0] load_value_i,
    output logic [WIDTH-1:0] count_o,
    output logic             expire_o
);
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ZERO = '0;

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } core_st_t;

    core_st_t st_d, st_q;
    step_e    step;

    always_comb begin
        st_d = st_q;
        if (load_valid_i) begin
            step = STEP_LOAD;
        end else if (st_q.count != ZERO) begin
            step = STEP_DECR;
        end else begin
            step = STEP_HOLD;
        end
        case (step)
            STEP_LOAD: st_d.count = load_value_i;
            STEP_DECR: st_d.count = st_q.count - ONE;
            default:   st_d.count = st_q.count;
        endcase
        expire_o = (step == STEP_DECR) && (st_q.count == ONE);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

    // R2
    assert_load_takes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_valid_i |=> count_o == $past(load_value_i));
    // R4
    assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_valid_i && count_o != ZERO) |=> count_o == $past(count_o) - ONE);
    // R5
    assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_valid_i && count_o == ZERO) |=> count_o == ZERO);

endmodule

// File: rtl/tmr_irq_pulse.sv
module tmr_irq_pulse (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic expire_i,
    output logic irq_o
);
    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = expire_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R6
    assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

endmodule

// File: rtl/cyc_timer.sv
module cyc_timer #(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_valid_i,
    input  logic [WIDTH-1:0] load_value_i,
    output logic [WIDTH-1:0] prev_value_o,
    output logic [WIDTH-1:0] count_o,
    output logic             irq_o
);
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] count_q;
    logic             expire;

    tmr_count_core #(.WIDTH(WIDTH)) core_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .load_valid_i (load_valid_i),
        .load_value_i (load_value_i),
        .count_o      (count_q),
        .expire_o     (expire)
    );

    tmr_irq_pulse irq_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .expire_i (expire),
        .irq_o    (irq_o)
    );

    assign count_o      = count_q;
    assign prev_value_o = count_q;

    // R6: a pulse only follows a 1 -> 0 step
    assert_irq_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (count_q == ZERO && $past(count_q) == ONE && !$past(load_valid_i)));
    // R8: a load on the last count suppresses the pulse
    assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_valid_i && count_q == ONE) |=> !irq_o);
    // R7: an idle counter raises nothing
    assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_q == ZERO && !load_valid_i) |=> !irq_o);

endmodule

// File: tb/cyc_timer_tb_top.sv
module cyc_timer_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        load_valid_i = 1'b0;
    logic [31:0] load_value_i = '0;
    logic [31:0] prev_value_o;
    logic [31:0] count_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk_i = ~clk_i;

    cyc_timer #(.WIDTH(32)) dut_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .load_valid_i (load_valid_i),
        .load_value_i (load_value_i),
        .prev_value_o (prev_value_o),
        .count_o      (count_o),
        .irq_o        (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Raise the strobe for one cycle, checking the returned old count.
    task automatic do_load(input logic [31:0] v, input logic [31:0] exp_prev, input string req);
        @(negedge clk_i);
        load_valid_i = 1'b1;
        load_value_i = v;
        #1;
        check(req, prev_value_o, exp_prev);
        @(negedge clk_i);
        load_valid_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 count", count_o, 32'd0);
        check("R1 irq", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_countdown;
        do_load(32'd5, 32'd0, "R3 prev from idle");
        check("R2 loaded", count_o, 32'd5);
        check("R6 no early irq", {31'd0, irq_o}, 32'd0);
        for (int k = 4; k >= 1; k--) begin
            @(negedge clk_i);
            check("R4 step", count_o, k[31:0]);
            check("R6 quiet", {31'd0, irq_o}, 32'd0);
        end
        @(negedge clk_i);
        check("R6 reached zero", count_o, 32'd0);
        check("R6 pulse", {31'd0, irq_o}, 32'd1);
        @(negedge clk_i);
        check("R6 pulse ends", {31'd0, irq_o}, 32'd0);
        check("R5 holds zero", count_o, 32'd0);
        repeat (5) @(negedge clk_i);
        check("R5 no wrap", count_o, 32'd0);
    endtask

    task automatic t_prev_midrun;
        do_load(32'd100, 32'd0, "R3 prev idle");
        repeat (3) @(negedge clk_i);
        check("R4 after three", count_o, 32'd97);
        load_valid_i = 1'b1;
        load_value_i = 32'd0;
        #1;
        check("R3 prev midrun", prev_value_o, 32'd97);
        @(negedge clk_i);
        load_valid_i = 1'b0;
        check("R7 stopped", count_o, 32'd0);
        begin
            int pulses = 0;
            for (int i = 0; i < 150; i++) begin
                @(negedge clk_i);
                if (irq_o) pulses++;
            end
            check("R7 no irq after stop", pulses[31:0], 32'd0);
        end
        check("R7 still zero", count_o, 32'd0);
    endtask

    task automatic t_collide;
        do_load(32'd2, 32'd0, "R3 prev idle");
        @(negedge clk_i);
        check("R8 reached one", count_o, 32'd1);
        load_valid_i = 1'b1;
        load_value_i = 32'd9;
        #1;
        check("R8 prev one", prev_value_o, 32'd1);
        @(negedge clk_i);
        load_valid_i = 1'b0;
        check("R8 new value", count_o, 32'd9);
        check("R8 no irq", {31'd0, irq_o}, 32'd0);
        @(negedge clk_i);
        check("R8 continues", count_o, 32'd8);
        check("R8 still no irq", {31'd0, irq_o}, 32'd0);
        do_load(32'd0, 32'd7, "R3 prev seven");
    endtask

    task automatic t_load_one;
        do_load(32'd1, 32'd0, "R3 prev idle");
        check("R9 reads one", count_o, 32'd1);
        check("R9 no irq yet", {31'd0, irq_o}, 32'd0);
        @(negedge clk_i);
        check("R9 zero", count_o, 32'd0);
        check("R9 pulse", {31'd0, irq_o}, 32'd1);
        @(negedge clk_i);
        check("R9 pulse over", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_top_value;
        do_load(32'hFFFF_FFFF, 32'd0, "R3 prev idle");
        check("R2 max loaded", count_o, 32'hFFFF_FFFF);
        @(negedge clk_i);
        check("R4 max step", count_o, 32'hFFFF_FFFE);
        do_load(32'd0, 32'hFFFF_FFFD, "R3 prev near max");
        check("R7 cleared", count_o, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_countdown();
        t_prev_midrun();
        t_collide();
        t_load_one();
        t_top_value();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule